// File: doc/BRIEF.md
# Reuse-Distance Replacement Controller

This block chooses which line to replace in a small, fully associative cache directory. It ranks lines by how far apart their references fall, not only by how recently they were used. A requester presents a block identifier. One cycle later the block answers hit or miss. On a miss that finds every resident slot taken, it also names the resident block to evict. The data array, the refill path and the backing store sit outside this block.

Resident capacity is split into a protected part and a probationary part. A history stack orders protected blocks by recency. It also holds entries for probationary blocks, both resident and already evicted. A short queue orders only the resident probationary blocks. A block moves between the two parts through promotion and demotion. After every operation the bottom of the history stack must be a protected entry. Probationary entries left below it are trimmed one per cycle, and `busy` stays high until the trimming is done.

Top module: `lirs_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `resp_valid` and `busy` are 0. The directory starts empty.
- R2: A miss is resident-protected while fewer than LIR_N protected blocks exist. Otherwise a miss with no history entry enters as resident-probationary. No eviction is reported while a free resident slot exists.
- R3: A hit to a protected block reports a hit and moves that block to the top of the history stack.
- R4: A hit to a resident-probationary block that has a history entry reports a hit and makes it protected. The bottom protected block becomes probationary and goes to the top of the queue.
- R5: A hit to a resident-probationary block with no history entry reports a hit. The block stays probationary and goes to the top of both the queue and the history stack.
- R6: A miss when all HIR_N probationary slots are occupied evicts the block at the bottom of the queue. The miss reports `resp_evict`=1 with that identifier on `resp_victim`. The evicted block's history entry is kept as non-resident.
- R7: A miss to a block with a non-resident history entry makes it resident-protected and demotes the bottom protected block into the queue.
- R8: While the bottom history entry is probationary, `busy` is 1 and exactly one entry is removed from the bottom per cycle.
- R9: A request presented while `busy` is 1 is ignored: it gets no response and leaves the state unchanged.
- R10: When a new probationary entry needs space in a full history stack of HIST_N entries, the deepest non-resident entry is dropped first.
- R11: `resp_valid` is 1 exactly in the cycle after an accepted request. `resp_evict` is only ever 1 together with a valid miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_id | input | ID_W | Block identifier of the request |
| busy | output | 1 | Trimming in progress; requests are ignored |
| resp_valid | output | 1 | Response for the request accepted last cycle |
| resp_hit | output | 1 | 1 = the block was resident |
| resp_evict | output | 1 | A resident block must be evicted |
| resp_victim | output | ID_W | Identifier of the block to evict |

## Verification
The bound assertions check the following on every cycle:
- response timing against acceptance;
- that an eviction only ever comes with a miss, and never names the requested block;
- that `busy` suppresses the next response;
- that each busy cycle removes exactly one history entry.

Which block is chosen as the victim, and whether a block was promoted, demoted or dropped from history, show only in the sequence of hits and victims. The bench's reference model checks these over loop, scan and pseudo-random reference patterns, and across a mid-run reset.

// File: rtl/lirs_ctrl.sv
module lirs_ctrl #(
  parameter int ID_W   = 8,
  parameter int LIR_N  = 3,
  parameter int HIR_N  = 2,
  parameter int HIST_N = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [ID_W-1:0] req_id,
  output logic            busy,
  output logic            resp_valid,
  output logic            resp_hit,
  output logic            resp_evict,
  output logic [ID_W-1:0] resp_victim
);
  localparam int CW = $clog2(HIST_N + 1);
  localparam int QW = $clog2(HIR_N + 1);
  localparam int LW = $clog2(LIR_N + 1);

  // entry: [ID_W+1] protected, [ID_W] resident, [ID_W-1:0] id
  typedef logic [ID_W+1:0] ent_t;
  typedef ent_t [HIST_N-1:0] stk_t;
  typedef logic [HIR_N-1:0][ID_W-1:0] hq_t;

  stk_t stk, n_stk;
  hq_t hq, n_hq;
  logic [CW-1:0] s_n, n_sn;
  logic [QW-1:0] q_n, n_qn;
  logic [LW-1:0] l_n, n_ln;
  logic s_hit, q_hit, bot_lir, hit, ev, dem, new_hir;
  logic [ID_W-1:0] vic, d_id;
  int s_idx, q_idx, drop_i;

  function automatic stk_t s_del(stk_t s, int k);
    stk_t r = s;
    for (int i = 0; i < HIST_N - 1; i++) if (i >= k) r[i] = s[i+1];
    r[HIST_N-1] = '0;
    return r;
  endfunction

  function automatic stk_t s_push(stk_t s, ent_t e);
    stk_t r;
    r[0] = e;
    for (int i = 1; i < HIST_N; i++) r[i] = s[i-1];
    return r;
  endfunction

  function automatic hq_t q_del(hq_t q, int k);
    hq_t r = q;
    for (int i = 0; i < HIR_N - 1; i++) if (i >= k) r[i] = q[i+1];
    r[HIR_N-1] = '0;
    return r;
  endfunction

  function automatic hq_t q_push(hq_t q, logic [ID_W-1:0] e);
    hq_t r;
    r[0] = e;
    for (int i = 1; i < HIR_N; i++) r[i] = q[i-1];
    return r;
  endfunction

  always_comb begin
    s_hit = 1'b0; s_idx = 0; q_hit = 1'b0; q_idx = 0; bot_lir = 1'b0;
    for (int i = 0; i < HIST_N; i++) begin
      if (i < int'(s_n) && stk[i][ID_W-1:0] == req_id) begin s_hit = 1'b1; s_idx = i; end
      if (i == int'(s_n) - 1) bot_lir = stk[i][ID_W+1];
    end
    for (int i = 0; i < HIR_N; i++)
      if (i < int'(q_n) && hq[i] == req_id) begin q_hit = 1'b1; q_idx = i; end
  end

  assign busy = (s_n != '0) && !bot_lir;

  always_comb begin
    n_stk = stk; n_hq = hq; n_sn = s_n; n_qn = q_n; n_ln = l_n;
    hit = 1'b0; ev = 1'b0; vic = '0; dem = 1'b0; new_hir = 1'b0; d_id = '0; drop_i = -1;
    if (busy) begin
      n_sn = s_n - 1'b1;
    end else if (req_valid) begin
      if (s_hit && stk[s_idx][ID_W+1]) begin
        hit = 1'b1;
        n_stk = s_push(s_del(stk, s_idx), {2'b11, req_id});
      end else if (q_hit) begin
        hit = 1'b1;
        n_hq = q_del(hq, q_idx);
        n_qn = q_n - 1'b1;
        if (s_hit) begin
          n_stk = s_push(s_del(stk, s_idx), {2'b11, req_id});
          dem = 1'b1;
        end else new_hir = 1'b1;
      end else if (int'(l_n) < LIR_N) begin
        n_stk = s_push(stk, {2'b11, req_id});
        n_sn = s_n + 1'b1;
        n_ln = l_n + 1'b1;
      end else begin
        if (int'(q_n) == HIR_N) begin
          ev = 1'b1;
          vic = hq[HIR_N-1];
          n_qn = q_n - 1'b1;
          for (int i = 0; i < HIST_N; i++)
            if (i < int'(s_n) && stk[i][ID_W-1:0] == vic) n_stk[i][ID_W] = 1'b0;
        end
        if (s_hit) begin
          n_stk = s_push(s_del(n_stk, s_idx), {2'b11, req_id});
          dem = 1'b1;
        end else new_hir = 1'b1;
      end
      if (new_hir) begin
        if (int'(n_sn) == HIST_N) begin
          for (int i = 0; i < HIST_N; i++)
            if (!n_stk[i][ID_W+1] && !n_stk[i][ID_W]) drop_i = i;
          if (drop_i >= 0) begin
            n_stk = s_del(n_stk, drop_i);
            n_sn = n_sn - 1'b1;
          end
        end
        n_stk = s_push(n_stk, {2'b01, req_id});
        n_sn = n_sn + 1'b1;
        n_hq = q_push(n_hq, req_id);
        n_qn = n_qn + 1'b1;
      end
      if (dem) begin
        for (int i = 0; i < HIST_N; i++)
          if (i == int'(n_sn) - 1) d_id = n_stk[i][ID_W-1:0];
        n_sn = n_sn - 1'b1;
        n_hq = q_push(n_hq, d_id);
        n_qn = n_qn + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk <= '0; hq <= '0; s_n <= '0; q_n <= '0; l_n <= '0;
      resp_valid <= 1'b0; resp_hit <= 1'b0; resp_evict <= 1'b0; resp_victim <= '0;
    end else begin
      stk <= n_stk; hq <= n_hq; s_n <= n_sn; q_n <= n_qn; l_n <= n_ln;
      resp_valid  <= req_valid && !busy;
      resp_hit    <= hit;
      resp_evict  <= ev;
      resp_victim <= vic;
    end
  end
endmodule

// File: rtl/lirs_chk.sv
module lirs_chk #(
  parameter int ID_W = 8,
  parameter int CW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [ID_W-1:0] req_id,
  input logic            busy,
  input logic            resp_valid,
  input logic            resp_hit,
  input logic            resp_evict,
  input logic [ID_W-1:0] resp_victim,
  input logic [CW-1:0]   s_n
);
  // R11
  resp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && !busy));
  // R11
  evict_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_evict |-> (resp_valid && !resp_hit));
  // R9
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !resp_valid);
  // R8
  prune_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (s_n == $past(s_n) - 1'b1));
  // R6
  victim_not_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_evict |-> (resp_victim != $past(req_id)));
endmodule

bind lirs_ctrl lirs_chk #(.ID_W(ID_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
  .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit),
  .resp_evict(resp_evict), .resp_victim(resp_victim), .s_n(s_n)
);

// File: tb/sim_lirs_ctrl.sv
`timescale 1ns/1ps
module sim_lirs_ctrl;
  localparam int ID_W = 8, LIR_N = 3, HIR_N = 2, HIST_N = 8;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [ID_W-1:0] req_id = '0;
  logic busy, resp_valid, resp_hit, resp_evict;
  logic [ID_W-1:0] resp_victim;

  lirs_ctrl #(.ID_W(ID_W), .LIR_N(LIR_N), .HIR_N(HIR_N), .HIST_N(HIST_N)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id), .busy(busy),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_evict(resp_evict),
    .resp_victim(resp_victim));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int lid[$]; bit llir[$]; bit lres[$]; int hq[$];
  int lcnt = 0, busy_left = 0, e_vic = 0;
  bit e_rv = 0, e_hit = 0, e_ev = 0;
  string tag = "R11";

  task automatic chk(bit ok, string t, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  function automatic int m_find(int id);
    for (int i = 0; i < lid.size(); i++) if (lid[i] == id) return i;
    return -1;
  endfunction

  task automatic m_del(int k);
    lid.delete(k); llir.delete(k); lres.delete(k);
  endtask

  task automatic m_push(int id, bit lir, bit res);
    lid.push_front(id); llir.push_front(lir); lres.push_front(res);
  endtask

  task automatic m_drop();
    if (lid.size() == HIST_N) begin
      int d = -1;
      for (int i = 0; i < lid.size(); i++) if (!llir[i] && !lres[i]) d = i;
      if (d >= 0) begin m_del(d); tag = "R10"; end
    end
  endtask

  task automatic m_demote();
    int b = lid.size() - 1;
    hq.push_front(lid[b]);
    m_del(b);
  endtask

  task automatic m_op(int x);
    int si = m_find(x);
    int qi = -1;
    for (int i = 0; i < hq.size(); i++) if (hq[i] == x) qi = i;
    e_hit = 0; e_ev = 0; e_vic = 0;
    if (si >= 0 && llir[si]) begin
      e_hit = 1; tag = "R3"; m_del(si); m_push(x, 1, 1);
    end else if (qi >= 0) begin
      e_hit = 1; hq.delete(qi);
      if (si >= 0) begin tag = "R4"; m_del(si); m_push(x, 1, 1); m_demote(); end
      else begin tag = "R5"; m_drop(); m_push(x, 0, 1); hq.push_front(x); end
    end else if (lcnt < LIR_N) begin
      tag = "R2"; m_push(x, 1, 1); lcnt++;
    end else begin
      tag = "R2";
      if (hq.size() == HIR_N) begin
        int v;
        e_vic = hq.pop_back(); e_ev = 1; tag = "R6";
        v = m_find(e_vic);
        if (v >= 0) lres[v] = 0;
      end
      if (si >= 0) begin tag = "R7"; m_del(si); m_push(x, 1, 1); m_demote(); end
      else begin m_drop(); m_push(x, 0, 1); hq.push_front(x); end
    end
    busy_left = 0;
    while (lid.size() > 0 && !llir[lid.size()-1]) begin
      m_del(lid.size() - 1); busy_left++;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      lid.delete(); llir.delete(); lres.delete(); hq.delete();
      lcnt = 0; busy_left = 0; e_rv = 0;
    end else if (busy_left > 0) begin
      busy_left--; e_rv = 0; tag = req_valid ? "R9" : "R8";
    end else if (req_valid) begin
      m_op(int'(req_id)); e_rv = 1;
    end else begin
      e_rv = 0; tag = "R11";
    end
  end

  task automatic compare();
    chk(busy == (busy_left > 0), "R8 busy", busy, busy_left > 0);
    chk(resp_valid == e_rv, {tag, " resp_valid"}, resp_valid, e_rv);
    if (e_rv) begin
      chk(resp_hit == e_hit, {tag, " hit"}, resp_hit, e_hit);
      chk(resp_evict == e_ev, {tag, " R6 evict"}, resp_evict, e_ev);
      if (e_ev) chk(int'(resp_victim) == e_vic, {tag, " R6 victim"}, resp_victim, e_vic);
    end
  endtask

  task automatic reset_seq();
    rst_n = 1'b0; req_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!resp_valid && !busy, "R1 reset", {resp_valid, busy}, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(!resp_valid && !busy, "R1 after reset", {resp_valid, busy}, 0);
  endtask

  logic [15:0] lfsr = 16'hACE1;
  initial begin
    reset_seq();
    for (int n = 0; n < 3000; n++) begin
      if (n == 1500) reset_seq();
      @(negedge clk);
      compare();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_valid = (n < 60) ? 1'b1 : (lfsr[1:0] != 2'b00);
      if (n < 60) req_id = ID_W'(n % 7);
      else if (n < 120) req_id = ID_W'(40 + n);
      else if (n < 400) req_id = ID_W'((n % 3 == 0) ? (n % 4) : (10 + lfsr[5:2] % 6));
      else req_id = ID_W'(lfsr[7:4]);
    end
    @(negedge clk);
    compare();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule